// File: doc/BRIEF.md
# Priority-Group Round-Robin Arbiter

This block picks one of up to sixteen requesting channels each cycle. Every channel has a fixed strength level from 0 to 7, set by a parameter, and 7 is the strongest. A channel in a stronger group always beats every channel in a weaker group. Among channels that tie at the strongest requesting level, the block shares grants in a rotating order. The scan starts one index above the channel that was granted last and wraps around at sixteen.

The grant is decoded in combinational logic from the request vector and a last-granted pointer. The only state in the block is that pointer. It moves to the granted channel on a cycle where the grant is valid and the consumer raises its accept strobe. One instance can serve a read path and another a write path, each with its own strength table. A parameter limits how many channels exist. Request bits at or above that count are treated as absent.

Top module: `prio_rr_arbiter`

## Requirements
- R1: When any enabled channel requests, the granted channel has the highest strength level among all enabled requesters, where level 7 beats level 0.
- R2: Among enabled requesters at the winning level, the grant goes to the first one found when scanning indices last+1, last+2, … modulo 16, where last is the last-granted pointer.
- R3: A channel whose index is at or above the channel-count parameter is never granted, even when its request bit is set.
- R4: The level output equals the configured strength of the granted channel, taken from bits [3i+2:3i] of the level parameter for channel i.
- R5: With no enabled requester, the valid output is 0 and both the index and level outputs are 0.
- R6: The last-granted pointer takes the granted index only at a clock edge where valid and accept are both 1. At any other edge, including one where accept is 1 and valid is 0, the pointer keeps its value.
- R7: Reset sets the last-granted pointer to 15, so channel 0 is the first one scanned after reset.
- R8: The grant outputs follow a change of the request vector in the same cycle, with no register between the requests and the grant.

Sections below use this table. Text wrapped across lines in a cell stays in that cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req | input | 16 | Request bit per channel |
| accept | input | 1 | Consumer takes the current grant |
| gnt_valid | output | 1 | A grant is offered |
| gnt_idx | output | 4 | Granted channel index |
| gnt_lvl | output | 3 | Strength level of the granted channel |

## Verification
The assertions check on every cycle that:
- the grant points at an enabled requester inside the channel range;
- no requester at a stronger level is passed over;
- no tied requester sits between the rotation start and the chosen index;
- the level output matches the table;
- an idle cycle drives zeros;
- the pointer follows an accepted grant and holds otherwise.

Only the bench's scenarios can show some behaviours:
- the pointer value right after reset;
- that rotation really cycles through tied channels over successive accepts;
- that both pick variants match a separate scan model across every request pattern of a small configuration.

// File: rtl/prr_pkg.sv
package prr_pkg;
   localparam int MAX_CH  = 16;
   localparam int CH_W    = $clog2(MAX_CH);
   localparam int LVL_W   = 3;
   localparam int NUM_LVL = 1 << LVL_W;

   typedef logic [MAX_CH-1:0] ch_vec_t;
   typedef logic [CH_W-1:0]   ch_idx_t;
   typedef logic [LVL_W-1:0]  lvl_t;

   function automatic lvl_t level_of(input logic [MAX_CH*LVL_W-1:0] table_v,
                                     input int ch);
      return table_v[ch*LVL_W +: LVL_W];
   endfunction
endpackage

// File: rtl/prr_level_filter.sv
module prr_level_filter
   import prr_pkg::*;
#(
   parameter int                        N_PORTS    = MAX_CH,
   parameter logic [MAX_CH*LVL_W-1:0]   PORT_LEVEL = '0
) (
   input  ch_vec_t req,
   output logic    any_req,
   output lvl_t    top_lvl,
   output ch_vec_t top_vec,
   output ch_vec_t live_vec
);
   ch_vec_t              port_en;
   ch_vec_t              lvl_vec [NUM_LVL];
   logic [NUM_LVL-1:0]   lvl_hit;

   genvar gc, gl;
   generate
      for (gc = 0; gc < MAX_CH; gc++) begin : g_en
         if (gc < N_PORTS) begin : g_on
            assign port_en[gc] = 1'b1;
         end else begin : g_off
            assign port_en[gc] = 1'b0;
         end
      end
   endgenerate

   assign live_vec = req & port_en;

   generate
      for (gl = 0; gl < NUM_LVL; gl++) begin : g_lvl
         ch_vec_t member;
         for (gc = 0; gc < MAX_CH; gc++) begin : g_mem
            assign member[gc] = (level_of(PORT_LEVEL, gc) == lvl_t'(gl));
         end
         assign lvl_vec[gl] = live_vec & member;
         assign lvl_hit[gl] = |lvl_vec[gl];
      end
   endgenerate

   always_comb begin
      top_lvl = '0;
      for (int l = 0; l < NUM_LVL; l++) begin
         if (lvl_hit[l]) top_lvl = lvl_t'(l);
      end
   end

   assign any_req = |lvl_hit;
   assign top_vec = lvl_vec[top_lvl];
endmodule

// File: rtl/prr_rotate_pick.sv
module prr_rotate_pick
   import prr_pkg::*;
#(
   parameter bit USE_MASK = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  ch_vec_t vec,
   input  ch_idx_t start,
   output logic    found,
   output ch_idx_t idx
);
   generate
      if (USE_MASK) begin : g_mask
         ch_vec_t upper;
         ch_idx_t lo_up, lo_all;
         always_comb begin
            for (int i = 0; i < MAX_CH; i++) upper[i] = vec[i] && (ch_idx_t'(i) >= start);
            lo_up  = '0;
            lo_all = '0;
            for (int i = MAX_CH-1; i >= 0; i--) begin
               if (upper[i]) lo_up  = ch_idx_t'(i);
               if (vec[i])   lo_all = ch_idx_t'(i);
            end
         end
         assign found = |vec;
         assign idx   = (|upper) ? lo_up : lo_all;
      end else begin : g_scan
         ch_idx_t cand;
         always_comb begin
            found = 1'b0;
            idx   = '0;
            cand  = '0;
            for (int k = 0; k < MAX_CH; k++) begin
               cand = start + ch_idx_t'(k);
               if (!found && vec[cand]) begin
                  found = 1'b1;
                  idx   = cand;
               end
            end
         end
      end
   endgenerate

   // R2: no set bit is skipped between the start and the pick
   always @(posedge clk) begin
      if (rst_n && found) begin
         a_r2_picked_set: assert (vec[idx]);
         for (int k = 0; k < MAX_CH; k++) begin
            if (ch_idx_t'(k) < ch_idx_t'(idx - start))
               a_r2_no_skip: assert (!vec[ch_idx_t'(start + ch_idx_t'(k))]);
         end
      end
   end
endmodule

// File: rtl/prr_last_ptr.sv
module prr_last_ptr
   import prr_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    load,
   input  ch_idx_t nxt,
   output ch_idx_t last
);
   localparam ch_idx_t RESET_PTR = ch_idx_t'(MAX_CH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    last <= RESET_PTR;
      else if (load) last <= nxt;
   end
endmodule

// File: rtl/prio_rr_arbiter.sv
module prio_rr_arbiter
   import prr_pkg::*;
#(
   parameter int                      N_PORTS    = MAX_CH,
   parameter logic [MAX_CH*LVL_W-1:0] PORT_LEVEL = '0,
   parameter bit                      USE_MASK   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [MAX_CH-1:0]     req,
   input  logic                  accept,
   output logic                  gnt_valid,
   output logic [CH_W-1:0]       gnt_idx,
   output logic [LVL_W-1:0]      gnt_lvl
);
   generate
      if (N_PORTS < 1 || N_PORTS > MAX_CH) begin : g_bad_ports
         $error("prio_rr_arbiter: N_PORTS out of range");
      end
      if ((1 << CH_W) != MAX_CH) begin : g_bad_width
         $error("prio_rr_arbiter: channel space must be a power of two");
      end
   endgenerate

   logic    any_req, found;
   lvl_t    top_lvl;
   ch_vec_t top_vec, live_vec;
   ch_idx_t last, pick;

   prr_level_filter #(.N_PORTS(N_PORTS), .PORT_LEVEL(PORT_LEVEL)) u_filter (
      .req(req), .any_req(any_req), .top_lvl(top_lvl),
      .top_vec(top_vec), .live_vec(live_vec)
   );

   prr_rotate_pick #(.USE_MASK(USE_MASK)) u_pick (
      .clk(clk), .rst_n(rst_n), .vec(top_vec), .start(last + ch_idx_t'(1)),
      .found(found), .idx(pick)
   );

   prr_last_ptr u_ptr (
      .clk(clk), .rst_n(rst_n), .load(gnt_valid && accept),
      .nxt(gnt_idx), .last(last)
   );

   assign gnt_valid = any_req && found;
   assign gnt_idx   = gnt_valid ? pick    : '0;
   assign gnt_lvl   = gnt_valid ? top_lvl : '0;

   always @(posedge clk) begin
      if (rst_n) begin
         if (gnt_valid) begin
            a_r3_in_range: assert (int'(gnt_idx) < N_PORTS && req[gnt_idx]);
            a_r4_level_match: assert (gnt_lvl == level_of(PORT_LEVEL, int'(gnt_idx)));
            for (int i = 0; i < MAX_CH; i++) begin
               if (live_vec[i])
                  a_r1_none_stronger: assert (level_of(PORT_LEVEL, i) <= gnt_lvl);
            end
         end
      end
   end

   a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (live_vec == '0) |-> (!gnt_valid && gnt_idx == '0 && gnt_lvl == '0));
   a_r6_ptr_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && accept) |=> (last == $past(gnt_idx)));
   a_r6_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(gnt_valid && accept) |=> $stable(last));
endmodule

// File: tb/prio_rr_arbiter_tb.sv
module prio_rr_arbiter_tb;
   localparam int PORTS = 12;

   function automatic logic [47:0] mk_levels();
      int t [16] = '{2, 5, 2, 7, 0, 5, 2, 7, 0, 1, 5, 0, 7, 7, 7, 7};
      logic [47:0] v = '0;
      for (int i = 0; i < 16; i++) v[i*3 +: 3] = 3'(t[i]);
      return v;
   endfunction
   localparam logic [47:0] LV = mk_levels();

   logic clk = 1'b0, rst_n = 1'b0, accept = 1'b0;
   logic [15:0] req = '0;
   logic v_a, v_b;
   logic [3:0] i_a, i_b;
   logic [2:0] l_a, l_b;
   int checks = 0, errors = 0;
   logic [3:0] mptr = 4'd15;

   always #2 clk = ~clk;

   prio_rr_arbiter #(.N_PORTS(PORTS), .PORT_LEVEL(LV), .USE_MASK(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .accept(accept),
      .gnt_valid(v_a), .gnt_idx(i_a), .gnt_lvl(l_a));
   prio_rr_arbiter #(.N_PORTS(PORTS), .PORT_LEVEL(LV), .USE_MASK(1'b0)) u_dut_scan (
      .clk(clk), .rst_n(rst_n), .req(req), .accept(accept),
      .gnt_valid(v_b), .gnt_idx(i_b), .gnt_lvl(l_b));

   task automatic model(input logic [15:0] r, input logic [3:0] p,
                        output logic ev, output logic [3:0] ei, output logic [2:0] el);
      ev = 1'b0; ei = '0; el = '0;
      for (int lv = 7; lv >= 0; lv--) begin
         for (int k = 0; k < 16; k++) begin
            logic [3:0] c = 4'(p + 4'd1 + 4'(k));
            if (!ev && int'(c) < PORTS && r[c] && LV[c*3 +: 3] == 3'(lv)) begin
               ev = 1'b1; ei = c; el = 3'(lv);
            end
         end
      end
   endtask

   task automatic cmp(input string tag, input logic ev, input logic [3:0] ei, input logic [2:0] el);
      checks++;
      if (v_a !== ev || i_a !== ei || l_a !== el) begin
         errors++;
         $display("FAIL %s mask: got v=%b i=%0d l=%0d expected v=%b i=%0d l=%0d", tag, v_a, i_a, l_a, ev, ei, el);
      end
      checks++;
      if (v_b !== ev || i_b !== ei || l_b !== el) begin
         errors++;
         $display("FAIL %s scan: got v=%b i=%0d l=%0d expected v=%b i=%0d l=%0d", tag, v_b, i_b, l_b, ev, ei, el);
      end
   endtask

   // drives one cycle, checks against the model, then tracks the pointer
   task automatic step(input logic [15:0] r, input logic a, input string tag);
      logic ev; logic [3:0] ei; logic [2:0] el;
      @(negedge clk);
      req = r; accept = a;
      #1;
      model(r, mptr, ev, ei, el);
      cmp(tag, ev, ei, el);
      @(posedge clk);
      if (ev && a) mptr = ei;
   endtask

   task automatic expect_idx(input logic [15:0] r, input logic a, input logic [3:0] want, input string tag);
      @(negedge clk);
      req = r; accept = a;
      #1;
      checks++;
      if (!v_a || i_a !== want) begin
         errors++;
         $display("FAIL %s: got v=%b i=%0d expected v=1 i=%0d", tag, v_a, i_a, want);
      end
      @(posedge clk);
      if (a) mptr = want;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      repeat (3) @(posedge clk);
      #1;
      cmp("R5 reset idle", 1'b0, 4'd0, 3'd0);
      @(negedge clk); rst_n = 1'b1;

      // R7: ties at level 2 on channels 0, 2, 6 -> channel 0 first
      expect_idx(16'h0045, 1'b0, 4'd0, "R7 first after reset");
      // R6: accept with no request leaves the pointer alone
      step(16'h0000, 1'b1, "R5 idle accept");
      expect_idx(16'h0045, 1'b0, 4'd0, "R6 pointer held on idle accept");
      // R2 rotation among level-5 channels 1, 5, 10
      expect_idx(16'h0422, 1'b1, 4'd1, "R2 rotate a");
      expect_idx(16'h0422, 1'b1, 4'd5, "R2 rotate b");
      expect_idx(16'h0422, 1'b0, 4'd10, "R6 no accept c");
      expect_idx(16'h0422, 1'b1, 4'd10, "R6 held without accept");
      expect_idx(16'h0422, 1'b1, 4'd1, "R2 wrap");
      // R1: strongest wins over weaker ones
      expect_idx(16'h0213, 1'b0, 4'd1, "R1 mixed levels");
      expect_idx(16'h0218, 1'b0, 4'd3, "R1 level 7 wins");
      // lone weak requester
      expect_idx(16'h0010, 1'b1, 4'd4, "R1 lone level 0");
      // R3: bits above total, all level 7, are ignored
      step(16'hF000, 1'b1, "R3 above total only");
      expect_idx(16'hF100, 1'b0, 4'd8, "R3 above total with weak");
      // R8: same-cycle response
      expect_idx(16'h0200, 1'b0, 4'd9, "R8 same cycle a");
      expect_idx(16'h0080, 1'b0, 4'd7, "R8 same cycle b");
      step(16'h0000, 1'b0, "R5 idle");

      // exhaustive request sweep with fixed pointer (R1 R3 R4 R5)
      for (int r = 0; r < 65536; r++) step(16'(r), 1'b0, "R4 sweep");
      // pseudo-random sweep with accepts moving the pointer (R2 R6)
      for (int n = 0; n < 20000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr, lfsr[3] | lfsr[8], "R2 random");
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule